// File: doc/BRIEF.md
# Seamless-First Bank Command Selector

This block chooses which queued memory request should be served next. Each decision takes a small queue of pending requests and a snapshot of the per-bank state. A request carries a valid flag, rank, bank, row and direction. The bank state holds whether a row is open, which row it is, and the cycles from which activate, precharge, read and write commands are allowed. The current cycle, the next free burst cycle, a direction-switch flag and the current bus direction complete the inputs.

The selector first looks for a row hit that can issue its column command with no gap on the data bus. If there is none, it works out, for every bank that has an eligible request, when the precharge/activate path would allow a column command. It marks the best banks in a rank-major bank mask. It also reports whether preparing that bank fits under the current bus traffic. Issuing commands and updating timers belong to the surrounding scheduler.

Every output is a registered function of the inputs present at the previous rising clock edge. There is no handshake, so the caller holds or changes the snapshot freely, one decision per cycle.

Top module: `bsel_top`

## Requirements
- R1: All outputs are registered. A decision reflects the inputs sampled at one rising edge and appears just after that edge. During reset: sel_idx=0, sel_hit=0, none_avail=1, early_mask=0, prep_hidden=0.
- R2: The target slot is next_burst_at plus T_CS when dir_switched is 1 (plus 0 otherwise), raised to now if that sum is smaller.
- R3: A row hit qualifies when all of these hold: the entry is eligible, its bank has a row open, the open row equals the request row, and the bank's read timer (q_is_rd=1) or write timer (q_is_rd=0) is at or before the target slot. The lowest queue index among qualifying hits is selected, with sel_hit=1.
- R4: An entry is eligible only when its valid bit is 1 and rank_idle for its rank is 1. Ineligible entries affect neither the selection nor the mask.
- R5: The activate cycle of a bank is computed from whether a row is open. With no row open, it is the larger of its activate timer and now. With a row open, it is the larger of its precharge timer and now, plus T_RP.
- R6: The column cycle of a bank is the larger of its activate cycle plus T_RCD and its read timer (bus_rd=1) or write timer (bus_rd=0). The bank is seamless when its column cycle is at or before the target slot.
- R7: Only banks with an eligible request are candidates. If any candidate is seamless, early_mask holds exactly the seamless candidates. Otherwise it holds the candidates whose activate cycle equals the smallest one. Bit index is rank*BANKS + bank.
- R8: prep_hidden is 1 when all of these hold: the mask is non-empty, and the activate cycle of the highest-indexed bank in the mask is at or before the hidden limit. The hidden limit is the larger of now and (target slot minus T_RCD), where the subtraction is taken as 0 when the target slot is below T_RCD.
- R9: With no qualifying hit, the lowest-index eligible entry whose bank bit is set in early_mask is selected, with sel_hit=0.
- R10: With no eligible entry, none_avail=1, sel_idx=0, sel_hit=0, early_mask=0 and prep_hidden=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | QDEPTH | Entry valid, bit i for entry i (0 oldest) |
| q_rank | input | QDEPTH*RW | Rank of each entry |
| q_bank | input | QDEPTH*BW | Bank within rank of each entry |
| q_row | input | QDEPTH*ROW_W | Row of each entry |
| q_is_rd | input | QDEPTH | 1 read, 0 write |
| rank_idle | input | RANKS | 1 when the rank may accept commands |
| bk_row_open | input | NB | A row is open in the bank |
| bk_open_row | input | NB*ROW_W | Open row per bank |
| bk_act_at | input | NB*TIME_W | Activate allowed cycle |
| bk_pre_at | input | NB*TIME_W | Precharge allowed cycle |
| bk_rd_at | input | NB*TIME_W | Read column allowed cycle |
| bk_wr_at | input | NB*TIME_W | Write column allowed cycle |
| now | input | TIME_W | Current cycle |
| next_burst_at | input | TIME_W | Earliest cycle for the next burst |
| dir_switched | input | 1 | Direction just changed |
| bus_rd | input | 1 | Current bus direction is read |
| sel_idx | output | QIW | Selected queue index |
| sel_hit | output | 1 | Selection is a seamless row hit |
| none_avail | output | 1 | No eligible entry |
| early_mask | output | NB | Rank-major mask of earliest banks |
| prep_hidden | output | 1 | Bank preparation hides under bus traffic |

## Verification
Every result is due one rising edge after the snapshot that produced it. The bench drives a snapshot on a falling edge and lets one rising edge pass. It then compares all five outputs on the next falling edge against a reference model evaluated on that same snapshot, before the next snapshot is driven. Directed snapshots cover these cases:
- the direction-switch penalty flipping a hit in and out of qualification;
- read versus write timers;
- a busy rank;
- ties in activate cycle;
- seamless banks overriding earlier activates;
- the hidden boundary.

Randomised snapshots follow.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int TIME_W = 16;
  typedef logic [TIME_W-1:0] cyc_t;

  function automatic cyc_t cyc_max(input cyc_t a, input cyc_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bsel_bank_eval.sv
module bsel_bank_eval
  import bsel_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RCD = 3
) (
  input  logic row_open,
  input  cyc_t act_allow,
  input  cyc_t pre_allow,
  input  cyc_t rd_allow,
  input  cyc_t wr_allow,
  input  cyc_t now,
  input  cyc_t target,
  input  logic bus_rd,
  output cyc_t act_cyc,
  output logic seamless
);
  cyc_t col_cyc;

  always_comb begin
    if (row_open) act_cyc = cyc_max(pre_allow, now) + cyc_t'(T_RP);
    else          act_cyc = cyc_max(act_allow, now);
    col_cyc  = cyc_max(bus_rd ? rd_allow : wr_allow, act_cyc + cyc_t'(T_RCD));
    seamless = (col_cyc <= target);
  end
endmodule

// File: rtl/bsel_mask.sv
module bsel_mask
  import bsel_pkg::*;
#(
  parameter int NB    = 8,
  parameter int T_RCD = 3
) (
  input  logic [NB-1:0]             want,
  input  logic [NB-1:0][TIME_W-1:0] act_cyc,
  input  logic [NB-1:0]             seam,
  input  cyc_t                      target,
  input  cyc_t                      now,
  output logic [NB-1:0]             mask,
  output logic                      hidden
);
  logic any_seam;
  cyc_t min_act, last_act, limit;

  always_comb begin
    any_seam = |(want & seam);
    min_act  = '1;
    for (int b = 0; b < NB; b++)
      if (want[b] && act_cyc[b] < min_act) min_act = act_cyc[b];
    last_act = '0;
    for (int b = 0; b < NB; b++) begin
      mask[b] = want[b] && (any_seam ? seam[b] : (act_cyc[b] == min_act));
      if (mask[b]) last_act = act_cyc[b];
    end
    limit  = cyc_max((target >= cyc_t'(T_RCD)) ? target - cyc_t'(T_RCD) : '0, now);
    hidden = (|mask) && (last_act <= limit);
  end
endmodule

// File: rtl/bsel_pick.sv
module bsel_pick #(
  parameter int QDEPTH = 8,
  parameter int QIW    = 3
) (
  input  logic [QDEPTH-1:0] hit_ok,
  input  logic [QDEPTH-1:0] in_mask,
  output logic [QIW-1:0]    idx,
  output logic              hit,
  output logic              any
);
  logic [QIW-1:0] hit_idx, msk_idx;

  always_comb begin
    hit_idx = '0;
    msk_idx = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (hit_ok[i])  hit_idx = QIW'(i);
      if (in_mask[i]) msk_idx = QIW'(i);
    end
    hit = |hit_ok;
    any = hit || (|in_mask);
    idx = hit ? hit_idx : (any ? msk_idx : '0);
  end
endmodule

// File: rtl/bsel_top.sv
module bsel_top
  import bsel_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int RANKS  = 2,
  parameter int BANKS  = 4,
  parameter int ROW_W  = 8,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3,
  parameter int T_CS   = 2,
  localparam int NB    = RANKS * BANKS,
  localparam int RW    = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BW    = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int QIW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [QDEPTH-1:0]      q_valid,
  input  logic [QDEPTH*RW-1:0]   q_rank,
  input  logic [QDEPTH*BW-1:0]   q_bank,
  input  logic [QDEPTH*ROW_W-1:0] q_row,
  input  logic [QDEPTH-1:0]      q_is_rd,
  input  logic [RANKS-1:0]       rank_idle,
  input  logic [NB-1:0]          bk_row_open,
  input  logic [NB*ROW_W-1:0]    bk_open_row,
  input  logic [NB*TIME_W-1:0]   bk_act_at,
  input  logic [NB*TIME_W-1:0]   bk_pre_at,
  input  logic [NB*TIME_W-1:0]   bk_rd_at,
  input  logic [NB*TIME_W-1:0]   bk_wr_at,
  input  logic [TIME_W-1:0]      now,
  input  logic [TIME_W-1:0]      next_burst_at,
  input  logic                   dir_switched,
  input  logic                   bus_rd,
  output logic [QIW-1:0]         sel_idx,
  output logic                   sel_hit,
  output logic                   none_avail,
  output logic [NB-1:0]          early_mask,
  output logic                   prep_hidden
);
  cyc_t target;
  logic [NB-1:0] want, seam, mask_c;
  logic [NB-1:0][TIME_W-1:0] act_cyc;
  logic [QDEPTH-1:0] elig, hit_ok, in_mask;
  logic hidden_c, hit_c, any_c;
  logic [QIW-1:0] idx_c;

  assign target = cyc_max(next_burst_at + (dir_switched ? cyc_t'(T_CS) : '0), now);

  // Per-entry decode: eligibility, row-hit readiness, candidate banks
  always_comb begin
    want = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      int   bi;
      cyc_t col_allow;
      bi = int'(q_rank[i*RW +: RW]) * BANKS + int'(q_bank[i*BW +: BW]);
      elig[i] = q_valid[i] && rank_idle[q_rank[i*RW +: RW]];
      col_allow = q_is_rd[i] ? bk_rd_at[bi*TIME_W +: TIME_W]
                             : bk_wr_at[bi*TIME_W +: TIME_W];
      hit_ok[i] = elig[i] && bk_row_open[bi] &&
                  (bk_open_row[bi*ROW_W +: ROW_W] == q_row[i*ROW_W +: ROW_W]) &&
                  (col_allow <= target);
      if (elig[i]) want[bi] = 1'b1;
    end
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      bsel_bank_eval #(.T_RP(T_RP), .T_RCD(T_RCD)) u_eval (
        .row_open (bk_row_open[b]),
        .act_allow(bk_act_at[b*TIME_W +: TIME_W]),
        .pre_allow(bk_pre_at[b*TIME_W +: TIME_W]),
        .rd_allow (bk_rd_at[b*TIME_W +: TIME_W]),
        .wr_allow (bk_wr_at[b*TIME_W +: TIME_W]),
        .now      (now),
        .target   (target),
        .bus_rd   (bus_rd),
        .act_cyc  (act_cyc[b]),
        .seamless (seam[b])
      );
    end
  endgenerate

  bsel_mask #(.NB(NB), .T_RCD(T_RCD)) u_mask (
    .want(want), .act_cyc(act_cyc), .seam(seam),
    .target(target), .now(now), .mask(mask_c), .hidden(hidden_c)
  );

  always_comb begin
    for (int i = 0; i < QDEPTH; i++)
      in_mask[i] = elig[i] &&
        mask_c[int'(q_rank[i*RW +: RW]) * BANKS + int'(q_bank[i*BW +: BW])];
  end

  bsel_pick #(.QDEPTH(QDEPTH), .QIW(QIW)) u_pick (
    .hit_ok(hit_ok), .in_mask(in_mask), .idx(idx_c), .hit(hit_c), .any(any_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx     <= '0;
      sel_hit     <= 1'b0;
      none_avail  <= 1'b1;
      early_mask  <= '0;
      prep_hidden <= 1'b0;
    end else begin
      sel_idx     <= idx_c;
      sel_hit     <= hit_c;
      none_avail  <= !any_c;
      early_mask  <= mask_c;
      prep_hidden <= hidden_c;
    end
  end
endmodule

// File: rtl/bsel_chk.sv
module bsel_chk #(
  parameter int QDEPTH = 8,
  parameter int RANKS  = 2,
  parameter int BANKS  = 4,
  parameter int RW     = 1,
  parameter int BW     = 2,
  parameter int QIW    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [QDEPTH-1:0]    q_valid,
  input logic [QDEPTH*RW-1:0] q_rank,
  input logic [QDEPTH*BW-1:0] q_bank,
  input logic [RANKS-1:0]     rank_idle,
  input logic [QIW-1:0]       sel_idx,
  input logic                 sel_hit,
  input logic                 none_avail,
  input logic [RANKS*BANKS-1:0] early_mask,
  input logic                 prep_hidden
);
  logic primed;
  logic [QDEPTH-1:0]    pv;
  logic [QDEPTH*RW-1:0] pr;
  logic [QDEPTH*BW-1:0] pb;
  logic [RANKS-1:0]     pidle;
  logic [RANKS*BANKS-1:0] idle_banks;
  logic sel_ok, sel_in_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0; pv <= '0; pr <= '0; pb <= '0; pidle <= '0;
    end else begin
      primed <= 1'b1; pv <= q_valid; pr <= q_rank; pb <= q_bank; pidle <= rank_idle;
    end
  end

  always_comb begin
    for (int r = 0; r < RANKS; r++)
      for (int b = 0; b < BANKS; b++) idle_banks[r*BANKS+b] = pidle[r];
    sel_ok = pv[sel_idx] && pidle[pr[int'(sel_idx)*RW +: RW]];
    sel_in_mask = early_mask[int'(pr[int'(sel_idx)*RW +: RW]) * BANKS +
                             int'(pb[int'(sel_idx)*BW +: BW])];
  end

  // R10: nothing eligible leaves the mask and flags clear
  assert_empty_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    none_avail |-> (early_mask == '0 && !sel_hit && !prep_hidden));
  // R4: masked banks lie only in ranks that were idle
  assert_mask_idle_rank_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (early_mask & ~idle_banks) == '0);
  // R4: a selected entry was valid and in an idle rank
  assert_sel_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !none_avail |-> sel_ok);
  // R8: hidden preparation needs a masked bank
  assert_hidden_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prep_hidden |-> early_mask != '0);
  // R9: a non-hit selection targets a masked bank
  assert_fallback_masked_R9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (!none_avail && !sel_hit) |-> sel_in_mask);
endmodule

bind bsel_top bsel_chk #(
  .QDEPTH(QDEPTH), .RANKS(RANKS), .BANKS(BANKS), .RW(RW), .BW(BW), .QIW(QIW)
) u_bsel_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank),
  .rank_idle(rank_idle), .sel_idx(sel_idx), .sel_hit(sel_hit),
  .none_avail(none_avail), .early_mask(early_mask), .prep_hidden(prep_hidden)
);

// File: tb/tb_bsel_top.sv
module tb_bsel_top;
  localparam int QD = 8, NR = 2, NBK = 4, NB = 8, ROWW = 8, TW = 16;
  localparam int TRP = 3, TRCD = 3, TCS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [QD-1:0] q_valid, q_is_rd;
  logic [QD-1:0] q_rank;
  logic [QD*2-1:0] q_bank;
  logic [QD*ROWW-1:0] q_row;
  logic [NR-1:0] rank_idle;
  logic [NB-1:0] bk_row_open;
  logic [NB*ROWW-1:0] bk_open_row;
  logic [NB*TW-1:0] bk_act_at, bk_pre_at, bk_rd_at, bk_wr_at;
  logic [TW-1:0] now, next_burst_at;
  logic dir_switched, bus_rd;
  logic [2:0] sel_idx;
  logic sel_hit, none_avail, prep_hidden;
  logic [NB-1:0] early_mask;

  bsel_top dut (.*);

  int checks = 0, errors = 0;
  int qv[QD], qr[QD], qb[QD], qrow[QD], qrd[QD], idle[NR];
  int bo[NB], brow[NB], bact[NB], bpre[NB], brd[NB], bwr[NB];
  int t_now, t_nb, t_sw, t_busrd;
  int e_idx, e_hit, e_none, e_mask, e_hid;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < QD; i++) begin qv[i]=0; qr[i]=0; qb[i]=0; qrow[i]=0; qrd[i]=1; end
    for (int r = 0; r < NR; r++) idle[r] = 1;
    for (int b = 0; b < NB; b++) begin bo[b]=0; brow[b]=0; bact[b]=0; bpre[b]=0; brd[b]=0; bwr[b]=0; end
    t_now = 100; t_nb = 100; t_sw = 0; t_busrd = 1;
  endtask

  task automatic drive();
    for (int i = 0; i < QD; i++) begin
      q_valid[i] = qv[i][0]; q_is_rd[i] = qrd[i][0]; q_rank[i] = qr[i][0];
      q_bank[i*2 +: 2] = qb[i][1:0]; q_row[i*ROWW +: ROWW] = qrow[i][ROWW-1:0];
    end
    for (int r = 0; r < NR; r++) rank_idle[r] = idle[r][0];
    for (int b = 0; b < NB; b++) begin
      bk_row_open[b] = bo[b][0]; bk_open_row[b*ROWW +: ROWW] = brow[b][ROWW-1:0];
      bk_act_at[b*TW +: TW] = bact[b][TW-1:0]; bk_pre_at[b*TW +: TW] = bpre[b][TW-1:0];
      bk_rd_at[b*TW +: TW] = brd[b][TW-1:0];   bk_wr_at[b*TW +: TW] = bwr[b][TW-1:0];
    end
    now = t_now[TW-1:0]; next_burst_at = t_nb[TW-1:0];
    dir_switched = t_sw[0]; bus_rd = t_busrd[0];
  endtask

  function automatic int imax(int a, int b); return a > b ? a : b; endfunction

  // Reference model written from the requirements
  task automatic model();
    int tgt, lim, minact, anyseam, last;
    int acts[NB], seams[NB], want[NB], el[QD];
    tgt = imax(t_nb + (t_sw ? TCS : 0), t_now);
    for (int b = 0; b < NB; b++) want[b] = 0;
    e_hit = 0; e_idx = -1;
    for (int i = 0; i < QD; i++) begin
      int g = qr[i]*NBK + qb[i];
      el[i] = qv[i] && idle[qr[i]];
      if (el[i]) want[g] = 1;
      if (el[i] && bo[g] && brow[g] == qrow[i] && (qrd[i] ? brd[g] : bwr[g]) <= tgt && e_idx < 0) begin
        e_idx = i; e_hit = 1;
      end
    end
    anyseam = 0; minact = 1 << 30;
    for (int b = 0; b < NB; b++) begin
      acts[b] = bo[b] ? imax(bpre[b], t_now) + TRP : imax(bact[b], t_now);
      seams[b] = imax(t_busrd ? brd[b] : bwr[b], acts[b] + TRCD) <= tgt;
      if (want[b] && seams[b]) anyseam = 1;
      if (want[b] && acts[b] < minact) minact = acts[b];
    end
    e_mask = 0; last = 0;
    for (int b = 0; b < NB; b++)
      if (want[b] && (anyseam ? seams[b] : acts[b] == minact)) begin
        e_mask |= (1 << b); last = acts[b];
      end
    lim = imax(tgt >= TRCD ? tgt - TRCD : 0, t_now);
    e_hid = (e_mask != 0) && (last <= lim);
    if (!e_hit)
      for (int i = QD - 1; i >= 0; i--)
        if (el[i] && e_mask[qr[i]*NBK + qb[i]]) e_idx = i;
    e_none = (e_idx < 0);
    if (e_none) e_idx = 0;
  endtask

  task automatic step(string tag);
    drive();
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag, e_hit ? "R3 sel_idx" : "R9 sel_idx", int'(sel_idx), e_idx);
    chk(tag, "R3 sel_hit", int'(sel_hit), e_hit);
    chk(tag, "R10 none_avail", int'(none_avail), e_none);
    chk(tag, "R7 early_mask", int'(early_mask), e_mask);
    chk(tag, "R8 prep_hidden", int'(prep_hidden), e_hid);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_all(); drive();
    @(negedge clk); @(negedge clk);
    // R1: reset values
    chk("R1", "reset sel_idx", int'(sel_idx), 0);
    chk("R1", "reset none_avail", int'(none_avail), 1);
    chk("R1", "reset early_mask", int'(early_mask), 0);
    chk("R1", "reset prep_hidden", int'(prep_hidden), 0);
    rst_n = 1'b1;

    clear_all(); step("R10");                       // empty queue

    // R3: two ready hits, oldest wins; entry 0 is a non-hit
    clear_all();
    qv[0]=1; qb[0]=1;
    qv[2]=1; qb[2]=2; qrow[2]=5; qv[3]=1; qb[3]=2; qrow[3]=5;
    bo[2]=1; brow[2]=5; brd[2]=90;
    step("R3");

    // R2: read timer 101 qualifies only with the switch penalty
    brd[2]=101; t_sw=1; step("R2");
    t_sw=0; step("R2");

    // R3: write entry uses the write timer
    clear_all();
    qv[1]=1; qb[1]=3; qrow[1]=7; qrd[1]=0; bo[3]=1; brow[3]=7; brd[3]=500; bwr[3]=99;
    step("R3");

    // R5/R6: closed bank vs open-row bank, earliest activate wins
    clear_all();
    qv[0]=1; qb[0]=3; qrow[0]=2; bo[3]=1; brow[3]=1; bpre[3]=90;
    qv[1]=1; qb[1]=0;
    step("R5");
    // R7: both seamless once the target slot is late
    t_nb=110; step("R7");
    // R6: write direction timer blocks bank 0
    t_busrd=0; bwr[0]=200; step("R6");
    // R8: hidden boundary
    clear_all(); qv[0]=1; qb[0]=0; bact[0]=100; step("R8");
    bact[0]=101; step("R8");
    // R7: tie on activate cycle across ranks
    clear_all(); qv[4]=1; qr[4]=1; qb[4]=2; qv[5]=1; qb[5]=1; step("R7");

    // R4: busy rank skipped, invalid entries ignored
    clear_all();
    qv[0]=1; qr[0]=1; qb[0]=0; qrow[0]=4; bo[4]=1; brow[4]=4; idle[1]=0;
    qv[1]=0; qb[1]=2; bo[2]=1; brow[2]=0;
    qv[3]=1; qb[3]=1; bact[1]=130;
    step("R4");
    idle[0]=0; step("R4");

    // Randomised snapshots
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < QD; i++) begin
        qv[i] = ($urandom % 3) != 0; qr[i] = $urandom % NR; qb[i] = $urandom % NBK;
        qrow[i] = $urandom % 3; qrd[i] = $urandom % 2;
      end
      for (int r = 0; r < NR; r++) idle[r] = ($urandom % 5) != 0;
      for (int b = 0; b < NB; b++) begin
        bo[b] = $urandom % 2; brow[b] = $urandom % 3;
        bact[b] = 95 + $urandom % 12; bpre[b] = 95 + $urandom % 12;
        brd[b] = 95 + $urandom % 16; bwr[b] = 95 + $urandom % 16;
      end
      t_now = 100; t_nb = 98 + $urandom % 10; t_sw = $urandom % 2; t_busrd = $urandom % 2;
      step("R4 R5 R6 R7 R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule